// File: doc/BRIEF.md
# Serial Receive Byte Queue with Threshold and Idle Timeout

This block buffers received characters for a 16550-style serial controller. A deserializer delivers bytes, and break conditions, on a one-cycle strobe, and the host takes them out through a read strobe on the data register. The block derives the line status the host sees: data ready, overrun and break. It also produces two signals for the interrupt logic. One is a flag that shows the stored count has reached a programmable threshold. The other is a character-timeout indication that asserts when data has sat unread for four character times.

The block works in two modes. With the queue enabled, up to `DEPTH` bytes (16 by default) are kept in arrival order. With the queue disabled, a single holding register is used instead. The character time is computed from the bit period, given in clock ticks, and the frame format: word length, parity enable and stop-bit count. The serial shifter and the baud generator are outside the block.

Top module: `rx_byte_queue`

## Requirements
- R1: After reset, `fill_count` is 0, `data_ready`, `overrun`, `break_seen`, `tmo_pend` and `trig_hit` are 0, `in_ready` is 1 and `rd_data` is 0x00.
- R2: In queue mode, bytes are read in arrival order. `rd_data` shows the oldest byte, and `rd_pop` removes it at the clock edge. `data_ready` is 1 exactly when `fill_count` is non-zero. A push and a pop in the same cycle leave `fill_count` unchanged.
- R3: `in_ready` is 0 while `DEPTH` bytes are stored. A byte that arrives while `DEPTH` bytes are stored is dropped, even if a pop happens in the same cycle. The stored bytes are kept and `overrun` is set.
- R4: `trig_sel` selects the threshold: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 bytes. In queue mode, `trig_hit` is 1 exactly when `fill_count` is at least the threshold.
- R5: The frame length is 1 start bit, plus `frame_cfg[1:0]`+5 data bits, plus 1 parity bit if `frame_cfg[3]` is set, plus 2 stop bits if `frame_cfg[2]` is set or 1 stop bit otherwise. The window W is 4 × `bit_ticks` × frame length. `tmo_pend` rises at the W-th clock edge after the last restart of the timeout, if data is then stored.
- R6: In queue mode, the timeout restarts on every arriving byte or break. It also restarts on a pop that leaves the queue non-empty.
- R7: `tmo_pend` clears on any `rd_pop`. It never asserts when the queue is empty at expiry.
- R8: In queue mode, a read of an empty queue returns 0x00 and changes nothing. A read that empties the queue clears `data_ready` and `break_seen`.
- R9: A `flush` pulse, or any change of `fifo_en`, empties the queue and the holding register. It clears `data_ready`, `break_seen` and `tmo_pend` one cycle later. `overrun` is kept.
- R10: In holding mode (`fifo_en`=0), `fill_count` is 0 or 1 and `in_ready` is always 1. `rd_data` shows the holding register, which a read does not clear. A byte that arrives while `data_ready` is set, with no read in the same cycle, overwrites the register and sets `overrun`. The timeout never asserts in this mode.
- R11: `in_break` stores a 0x00 byte and sets both `break_seen` and `data_ready`. It takes priority over `in_valid` in the same cycle.
- R12: `stat_rd` clears `overrun` and `break_seen`. An event that sets either flag in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | 1: queue mode, 0: single holding register |
| flush | input | 1 | Pulse: discard all stored data |
| trig_sel | input | 2 | Threshold select (1/4/8/14 bytes) |
| frame_cfg | input | 4 | [1:0] word length−5, [2] two stop bits, [3] parity enable |
| bit_ticks | input | BT_W (16) | Bit period in clock ticks, at least 1 |
| in_valid | input | 1 | Strobe: received byte on `in_data` |
| in_data | input | 8 | Received byte |
| in_break | input | 1 | Strobe: break condition received |
| in_ready | output | 1 | Room for another byte |
| rd_pop | input | 1 | Host read of the data register |
| rd_data | output | 8 | Data register value |
| stat_rd | input | 1 | Host read of line status; clears overrun and break |
| data_ready | output | 1 | Data available |
| overrun | output | 1 | A byte was lost or overwritten |
| break_seen | output | 1 | A break was received |
| trig_hit | output | 1 | Stored count at or above threshold |
| tmo_pend | output | 1 | Character timeout pending |
| fill_count | output | CNT_W (5) | Number of stored bytes |

## Verification
The embedded assertions check the following on every cycle:
- that the storage is never pushed when full or popped when empty;
- that a push paired with a pop keeps the count;
- that a dropped byte leaves the queue full and sets overrun;
- that a flush empties everything one cycle later;
- that a timeout only rises over stored data;
- that a timeout restart loads the full window.

Only the directed scenarios can show the following:
- the byte order through the queue;
- the exact edge at which the timeout fires for two different frame formats;
- the move of that edge when a pop re-arms the window;
- the four threshold levels;
- the overwrite behaviour of holding mode.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        TRIG_ONE      = 2'b00,
        TRIG_FOUR     = 2'b01,
        TRIG_EIGHT    = 2'b10,
        TRIG_FOURTEEN = 2'b11
    } trig_sel_e;

    // Frame format as decoded by the neighbouring line-control register.
    typedef struct packed {
        logic       par_en;
        logic       stop2;
        logic [1:0] wlen;
    } frame_cfg_t;

    // One arrival from the deserializer.
    typedef struct packed {
        logic  valid;
        logic  brk;
        byte_t data;
    } rx_arrival_t;

    // Total bits per character: start, data, optional parity, stop.
    function automatic logic [3:0] frame_bits(input frame_cfg_t c);
        logic [3:0] n;
        n = 4'd1 + 4'd5 + {2'b00, c.wlen} + {3'b000, c.par_en};
        n = n + (c.stop2 ? 4'd2 : 4'd1);
        return n;
    endfunction

    // Nonlinear threshold table.
    function automatic logic [4:0] trig_level(input logic [1:0] sel);
        logic [4:0] lvl;
        case (trig_sel_e'(sel))
            TRIG_ONE:      lvl = 5'd1;
            TRIG_FOUR:     lvl = 5'd4;
            TRIG_EIGHT:    lvl = 5'd8;
            default:       lvl = 5'd14;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             push,
    input  logic             pop,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     rdata,
    output logic [CNT_W-1:0] count
);
    localparam logic [AW-1:0]    LAST_IDX = AW'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            end
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign rdata = mem[rd_ptr];

    // R3: the controller never writes into a full store
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        push |-> (count != FULL_CNT));

    // R8: the controller never pops an empty store
    a_r8_no_underflow: assert property (@(posedge clk) disable iff (rst)
        pop |-> (count != '0));

    // R2: simultaneous push and pop keep the occupancy
    a_r2_pushpop_stable: assert property (@(posedge clk) disable iff (rst)
        (push && pop && !clr) |=> $stable(count));

endmodule

// File: rtl/rxq_tmo_timer.sv
module rxq_tmo_timer
    import rxq_pkg::*;
#(
    parameter int BT_W = 16,
    localparam int TMO_W = BT_W + 6
) (
    input  logic            clk,
    input  logic            rst,
    input  frame_cfg_t      cfg,
    input  logic [BT_W-1:0] bit_ticks,
    input  logic            restart,
    input  logic            cancel,
    output logic            expire
);
    logic [TMO_W-1:0] char_ticks;
    logic [TMO_W-1:0] window;
    logic [TMO_W-1:0] cnt;
    logic             armed;

    assign char_ticks = TMO_W'(bit_ticks) * TMO_W'(frame_bits(cfg));
    assign window     = char_ticks << 2;

    always_ff @(posedge clk) begin
        if (rst || cancel) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (restart) begin
            armed <= 1'b1;
            cnt   <= window - 1'b1;
        end else if (armed) begin
            if (cnt == '0) begin
                armed <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign expire = armed && (cnt == '0) && !restart && !cancel;

    // R6: a restart loads a full four-character window
    a_r6_restart_loads: assert property (@(posedge clk) disable iff (rst)
        (restart && !cancel) |=> (armed && (cnt == $past(window) - 1'b1)));

endmodule

// File: rtl/rxq_flag.sv
module rxq_flag #(
    parameter bit SET_WINS = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);
    logic nxt;

    generate
        if (SET_WINS) begin : g_set_first
            assign nxt = set || (q && !clr);

            // R12: a setting event beats a clearing one in the same cycle
            a_r12_set_priority: assert property (@(posedge clk) disable iff (rst)
                set |=> q);
        end else begin : g_clr_first
            assign nxt = !clr && (set || q);

            // R7: a clearing event beats a setting one in the same cycle
            a_r7_clear_priority: assert property (@(posedge clk) disable iff (rst)
                clr |=> !q);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/rx_byte_queue.sv
module rx_byte_queue
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int BT_W  = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fifo_en,
    input  logic             flush,
    input  logic [1:0]       trig_sel,
    input  logic [3:0]       frame_cfg,
    input  logic [BT_W-1:0]  bit_ticks,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_break,
    output logic             in_ready,
    input  logic             rd_pop,
    output logic [7:0]       rd_data,
    input  logic             stat_rd,
    output logic             data_ready,
    output logic             overrun,
    output logic             break_seen,
    output logic             trig_hit,
    output logic             tmo_pend,
    output logic [CNT_W-1:0] fill_count
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

    frame_cfg_t  cfg;
    rx_arrival_t arr;
    logic        mode_q;
    logic        clr_all;

    assign cfg = frame_cfg_t'(frame_cfg);

    // Break wins over a data byte in the same cycle and stores 0x00.
    always_comb begin
        arr.valid = in_valid || in_break;
        arr.brk   = in_break;
        arr.data  = in_break ? byte_t'(0) : in_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= 1'b0;
        end else begin
            mode_q <= fifo_en;
        end
    end

    assign clr_all = flush || (fifo_en != mode_q);

    // Queue-mode datapath
    logic [CNT_W-1:0] q_cnt;
    byte_t            q_head;
    logic             q_full, q_empty;
    logic             q_push, q_drop, q_pop, q_left_data;

    assign q_full      = (q_cnt == FULL_CNT);
    assign q_empty     = (q_cnt == '0);
    assign q_push      = mode_q && arr.valid && !clr_all && !q_full;
    assign q_drop      = mode_q && arr.valid && !clr_all && q_full;
    assign q_pop       = mode_q && rd_pop && !clr_all && !q_empty;
    assign q_left_data = (q_cnt > ONE_CNT) || q_push;

    rxq_store #(
        .DEPTH (DEPTH),
        .W     (BYTE_W)
    ) u_store (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr_all),
        .push  (q_push),
        .pop   (q_pop),
        .wdata (arr.data),
        .rdata (q_head),
        .count (q_cnt)
    );

    // Holding-register datapath
    byte_t hold_q;
    logic  hold_full;
    logic  h_arr, h_rd, h_over;

    assign h_arr  = !mode_q && arr.valid && !clr_all;
    assign h_rd   = !mode_q && rd_pop && !clr_all;
    assign h_over = h_arr && hold_full && !rd_pop;

    always_ff @(posedge clk) begin
        if (rst || clr_all) begin
            hold_q    <= '0;
            hold_full <= 1'b0;
        end else if (h_arr) begin
            hold_q    <= arr.data;
            hold_full <= 1'b1;
        end else if (h_rd) begin
            hold_full <= 1'b0;
        end
    end

    // Timeout
    logic tmo_restart, tmo_cancel, tmo_expire;

    assign tmo_cancel  = clr_all || !mode_q;
    assign tmo_restart = mode_q && !clr_all && (arr.valid || (q_pop && q_left_data));

    rxq_tmo_timer #(
        .BT_W (BT_W)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .bit_ticks (bit_ticks),
        .restart   (tmo_restart),
        .cancel    (tmo_cancel),
        .expire    (tmo_expire)
    );

    // Status flags
    logic emptied;
    logic oe_set, bi_set, bi_clr, to_set, to_clr;

    assign emptied = (q_pop && (q_cnt == ONE_CNT) && !q_push) || (h_rd && !h_arr);
    assign oe_set  = q_drop || h_over;
    assign bi_set  = arr.brk && !clr_all;
    assign bi_clr  = clr_all || stat_rd || emptied;
    assign to_set  = mode_q && tmo_expire && !q_empty;
    assign to_clr  = clr_all || rd_pop || !mode_q;

    rxq_flag #(.SET_WINS(1'b1)) u_oe (
        .clk (clk), .rst (rst), .set (oe_set), .clr (stat_rd), .q (overrun)
    );

    rxq_flag #(.SET_WINS(1'b1)) u_bi (
        .clk (clk), .rst (rst), .set (bi_set), .clr (bi_clr), .q (break_seen)
    );

    rxq_flag #(.SET_WINS(1'b0)) u_to (
        .clk (clk), .rst (rst), .set (to_set), .clr (to_clr), .q (tmo_pend)
    );

    // Outputs
    logic [CNT_W-1:0] level;

    assign level      = CNT_W'(trig_level(trig_sel));
    assign fill_count = mode_q ? q_cnt : CNT_W'(hold_full);
    assign data_ready = (fill_count != '0);
    assign in_ready   = !mode_q || !q_full;
    assign rd_data    = mode_q ? (q_empty ? byte_t'(0) : q_head) : hold_q;
    assign trig_hit   = mode_q ? (q_cnt >= level) : hold_full;

    // R3: a dropped byte leaves the queue full and flags overrun
    a_r3_drop_keeps: assert property (@(posedge clk) disable iff (rst)
        (q_drop && !rd_pop) |=> ((fill_count == FULL_CNT) && overrun));

    // R9: flush or mode change empties everything
    a_r9_flush_empties: assert property (@(posedge clk) disable iff (rst)
        clr_all |=> ((fill_count == '0) && !data_ready && !break_seen && !tmo_pend));

    // R7: a timeout only rises over stored data
    a_r7_tmo_needs_data: assert property (@(posedge clk) disable iff (rst)
        $rose(tmo_pend) |-> ($past(fill_count) != '0));

    // R8: an empty queue reads as zero
    a_r8_empty_read_zero: assert property (@(posedge clk) disable iff (rst)
        (mode_q && rd_pop && (fill_count == '0)) |-> (rd_data == 8'h00));

    // R10: overwrite in holding mode flags overrun and keeps data ready
    a_r10_overwrite_oe: assert property (@(posedge clk) disable iff (rst)
        h_over |=> (overrun && data_ready));

    // R11: a break leaves data ready with the break flag raised
    a_r11_break_sets: assert property (@(posedge clk) disable iff (rst)
        (in_break && !clr_all) |=> (break_seen && data_ready));

endmodule

// File: tb/rx_byte_queue_bench.sv
module rx_byte_queue_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int BT_W       = 16;
    localparam int CNT_W      = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst;
    logic             fifo_en, flush, in_valid, in_break, rd_pop, stat_rd;
    logic [1:0]       trig_sel;
    logic [3:0]       frame_cfg;
    logic [BT_W-1:0]  bit_ticks;
    logic [7:0]       in_data;
    logic             in_ready, data_ready, overrun, break_seen, trig_hit, tmo_pend;
    logic [7:0]       rd_data;
    logic [CNT_W-1:0] fill_count;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rx_byte_queue #(.DEPTH(DEPTH), .BT_W(BT_W)) u_rx_byte_queue (
        .clk        (clk),
        .rst        (rst),
        .fifo_en    (fifo_en),
        .flush      (flush),
        .trig_sel   (trig_sel),
        .frame_cfg  (frame_cfg),
        .bit_ticks  (bit_ticks),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_break   (in_break),
        .in_ready   (in_ready),
        .rd_pop     (rd_pop),
        .rd_data    (rd_data),
        .stat_rd    (stat_rd),
        .data_ready (data_ready),
        .overrun    (overrun),
        .break_seen (break_seen),
        .trig_hit   (trig_hit),
        .tmo_pend   (tmo_pend),
        .fill_count (fill_count)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pop_chk(input logic [7:0] exp, input string req);
        @(negedge clk);
        rd_pop = 1'b1;
        chk(req, rd_data, exp);
        @(negedge clk);
        rd_pop = 1'b0;
    endtask

    task automatic flush_q;
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic status_read;
        @(negedge clk);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    function automatic int win(input logic [3:0] f, input int bt);
        int fl;
        fl = 1 + (int'(f[1:0]) + 5) + (f[3] ? 1 : 0) + (f[2] ? 2 : 1);
        return 4 * bt * fl;
    endfunction

    task automatic t_reset;
        chk("R1 fill", fill_count, 0);
        chk("R1 data_ready", data_ready, 0);
        chk("R1 overrun", overrun, 0);
        chk("R1 break", break_seen, 0);
        chk("R1 tmo", tmo_pend, 0);
        chk("R1 trig", trig_hit, 0);
        chk("R1 in_ready", in_ready, 1);
        chk("R1 rd_data", rd_data, 8'h00);
    endtask

    task automatic t_order;
        flush_q();
        push(8'h11);
        push(8'h22);
        push(8'h33);
        chk("R2 fill after 3", fill_count, 3);
        chk("R2 data_ready", data_ready, 1);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 8'h44;
        rd_pop   = 1'b1;
        chk("R2 head during push+pop", rd_data, 8'h11);
        @(negedge clk);
        in_valid = 1'b0;
        rd_pop   = 1'b0;
        chk("R2 push+pop keeps count", fill_count, 3);
        pop_chk(8'h22, "R2 order b");
        pop_chk(8'h33, "R2 order c");
        pop_chk(8'h44, "R2 order d");
        chk("R2 drained fill", fill_count, 0);
        chk("R2 drained data_ready", data_ready, 0);
    endtask

    task automatic t_empty_read;
        pop_chk(8'h00, "R8 empty read value");
        chk("R8 empty read count", fill_count, 0);
    endtask

    task automatic t_full;
        flush_q();
        for (int i = 1; i <= DEPTH; i++) push(8'(i));
        chk("R3 fill full", fill_count, DEPTH);
        chk("R3 in_ready low", in_ready, 0);
        chk("R3 no overrun yet", overrun, 0);
        push(8'hEE);
        chk("R3 drop keeps count", fill_count, DEPTH);
        chk("R3 overrun set", overrun, 1);
        @(negedge clk);
        rd_pop   = 1'b1;
        in_valid = 1'b1;
        in_data  = 8'hDD;
        chk("R3 head kept", rd_data, 8'h01);
        @(negedge clk);
        rd_pop   = 1'b0;
        in_valid = 1'b0;
        chk("R3 push at full with pop dropped", fill_count, DEPTH - 1);
        for (int i = 2; i <= DEPTH; i++) pop_chk(8'(i), "R3 stored content");
        chk("R3 empty afterwards", fill_count, 0);
        push(8'h5C);
        flush_q();
        chk("R9 flush empties", fill_count, 0);
        chk("R9 overrun kept over flush", overrun, 1);
        status_read();
        chk("R12 status read clears overrun", overrun, 0);
    endtask

    task automatic t_trigger;
        for (int s = 0; s < 4; s++) begin
            int lvl;
            lvl = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
            trig_sel = 2'(s);
            flush_q();
            for (int i = 0; i < lvl - 1; i++) push(8'(i));
            chk($sformatf("R4 below level %0d", lvl), trig_hit, 0);
            push(8'hA5);
            chk($sformatf("R4 at level %0d", lvl), trig_hit, 1);
        end
        trig_sel = 2'b00;
        flush_q();
    endtask

    task automatic t_timeout(input logic [3:0] f, input int bt);
        int w;
        w = win(f, bt);
        frame_cfg = f;
        bit_ticks = BT_W'(bt);
        flush_q();
        push(8'h7E);
        tick(w - 1);
        chk($sformatf("R5 no timeout before %0d", w), tmo_pend, 0);
        tick(1);
        chk($sformatf("R5 timeout at %0d", w), tmo_pend, 1);
        pop_chk(8'h7E, "R5 data under timeout");
        chk("R7 read clears timeout", tmo_pend, 0);
    endtask

    task automatic t_rearm;
        int w;
        frame_cfg = 4'b0011;
        bit_ticks = BT_W'(2);
        w = win(frame_cfg, 2);
        flush_q();
        push(8'hA1);
        push(8'hB2);
        tick(30);
        pop_chk(8'hA1, "R6 first pop");
        tick(w - 1);
        chk("R6 window restarted by pop", tmo_pend, 0);
        tick(1);
        chk("R6 timeout after rearm", tmo_pend, 1);
        pop_chk(8'hB2, "R6 second pop");
        chk("R7 cleared by read", tmo_pend, 0);
        push(8'hC3);
        tick(10);
        pop_chk(8'hC3, "R7 emptying pop");
        tick(w + 5);
        chk("R7 no timeout when empty", tmo_pend, 0);
    endtask

    task automatic t_break;
        flush_q();
        @(negedge clk);
        in_break = 1'b1;
        in_valid = 1'b1;
        in_data  = 8'h55;
        @(negedge clk);
        in_break = 1'b0;
        in_valid = 1'b0;
        chk("R11 break stores one byte", fill_count, 1);
        chk("R11 break flag", break_seen, 1);
        chk("R11 data ready", data_ready, 1);
        chk("R11 stored zero", rd_data, 8'h00);
        pop_chk(8'h00, "R11 read break byte");
        chk("R8 emptying read clears break", break_seen, 0);
        chk("R8 emptying read clears data ready", data_ready, 0);
        @(negedge clk);
        in_break = 1'b1;
        @(negedge clk);
        in_break = 1'b1;
        stat_rd  = 1'b1;
        @(negedge clk);
        in_break = 1'b0;
        stat_rd  = 1'b0;
        chk("R12 set wins over status read", break_seen, 1);
        status_read();
        chk("R12 status read clears break", break_seen, 0);
        chk("R12 data kept after status read", fill_count, 2);
    endtask

    task automatic t_flush;
        int w;
        w = win(frame_cfg, int'(bit_ticks));
        flush_q();
        push(8'h01);
        @(negedge clk);
        in_break = 1'b1;
        @(negedge clk);
        in_break = 1'b0;
        tick(w + 2);
        chk("R9 setup timeout", tmo_pend, 1);
        chk("R9 setup break", break_seen, 1);
        flush_q();
        chk("R9 flush fill", fill_count, 0);
        chk("R9 flush data ready", data_ready, 0);
        chk("R9 flush break", break_seen, 0);
        chk("R9 flush timeout", tmo_pend, 0);
        push(8'h02);
        push(8'h03);
        @(negedge clk);
        fifo_en = 1'b0;
        @(negedge clk);
        chk("R9 mode change empties", fill_count, 0);
        fifo_en = 1'b1;
        tick(2);
        chk("R9 back in queue mode empty", fill_count, 0);
    endtask

    task automatic t_hold;
        int w;
        w = win(frame_cfg, int'(bit_ticks));
        @(negedge clk);
        fifo_en = 1'b0;
        tick(2);
        push(8'h5A);
        chk("R10 holding count", fill_count, 1);
        chk("R10 holding data ready", data_ready, 1);
        chk("R10 holding value", rd_data, 8'h5A);
        chk("R10 no overrun", overrun, 0);
        push(8'h6B);
        chk("R10 overwrite value", rd_data, 8'h6B);
        chk("R10 overwrite overrun", overrun, 1);
        chk("R10 count capped", fill_count, 1);
        chk("R10 in_ready", in_ready, 1);
        pop_chk(8'h6B, "R10 read holding");
        chk("R10 read clears data ready", data_ready, 0);
        chk("R10 register keeps value", rd_data, 8'h6B);
        status_read();
        chk("R12 overrun cleared", overrun, 0);
        push(8'h11);
        tick(w + 5);
        chk("R10 no timeout in holding mode", tmo_pend, 0);
    endtask

    initial begin
        rst       = 1'b1;
        fifo_en   = 1'b0;
        flush     = 1'b0;
        in_valid  = 1'b0;
        in_break  = 1'b0;
        rd_pop    = 1'b0;
        stat_rd   = 1'b0;
        trig_sel  = 2'b00;
        frame_cfg = 4'b0011;
        bit_ticks = BT_W'(2);
        in_data   = 8'h00;
        tick(3);
        rst = 1'b0;
        tick(1);
        t_reset();
        fifo_en = 1'b1;
        tick(2);
        t_order();
        t_empty_read();
        t_full();
        t_trigger();
        t_timeout(4'b0011, 2);
        t_timeout(4'b1100, 3);
        t_rearm();
        t_break();
        t_flush();
        t_hold();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule